// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

This block gathers up to eight device interrupt requests into one level-sensitive line for an upstream interrupt controller. Devices set bits in a pending register with single-cycle request pulses and remove them with clear pulses. A host processor controls which requests may reach the output through an enable mask. It reads the pending bits through a status register. It retires a serviced request by writing that request's index to an acknowledge register. No priority is resolved and no vector is produced. The upstream side only learns that at least one enabled request is waiting.

The host mask register uses inverted polarity. A 1 written to a bit blocks that request, and the value read back is the value the host wrote. A second mask register and a second status register sit in the map so that software written for a cascaded pair still finds them. The second mask only stores what is written to it. The second status always reads zero. Host reads have no side effects and return data in the same cycle.

Register map (host_addr): 0 = enable mask port, read/write, inverted. 1 = pending status, read-only. 2 = acknowledge, write-only. 3 = auxiliary mask, read/write. 4 = auxiliary status, read-only. Every other address reads zero and ignores writes.

Top module: `irq_mask_agg`

## Requirements
- R1: While rst_n is low and on its release, the pending register, the enable mask and the auxiliary mask are zero and irq_out is low. As a result, address 0 reads all ones, and addresses 1 and 3 read zero.
- R2: A host write to address 0 stores the bitwise inverse of host_wdata as the enable mask. A read of address 0 returns the inverse of the stored mask, which is the last value written.
- R3: Every bit set in dev_post is set in the pending register at the next clock edge. Bits already pending stay set. Address 1 reads the pending register.
- R4: Every bit set in dev_clear is cleared in the pending register at the next clock edge.
- R5: A host write to address 2 clears the pending bit whose index is host_wdata[3:0]. The upper bits of host_wdata are ignored. An index at or above the line count clears nothing.
- R6: When a post and a clear (from dev_clear or an acknowledge) hit the same bit in one cycle, the bit ends up cleared.
- R7: From the edge at which a mask write, post, clear or acknowledge takes effect, irq_out is high exactly when (pending AND enable mask) is nonzero.
- R8: In a cycle with no mask write, post, clear or acknowledge, irq_out keeps its value at the next edge.
- R9: A host write to address 3 stores host_wdata unchanged. Address 3 reads it back, and the write has no effect on irq_out or on the pending register.
- R10: Address 4 always reads zero. Writes to addresses 1, 4 and unmapped addresses change no readable state and do not change irq_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one write per high cycle |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr, same cycle |
| dev_post | input | 8 | Device request pulses, one bit per line |
| dev_clear | input | 8 | Device clear pulses, one bit per line |
| irq_out | output | 1 | Level interrupt to the upstream controller |

## Verification
The bench builds the block with its default parameters: eight request lines, a three-bit address and a four-bit acknowledge index. These defaults bring the acknowledge index range above the line count within reach. Index 8 must clear nothing, and index 7 with a set upper nibble must still clear bit 7. Bit 7 also sits at the top edge of the mask inversion and of the pending register. With eight lines, every row of the vector table can state its expected status byte directly.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Host register offsets
  localparam int unsigned REG_EN       = 0;
  localparam int unsigned REG_STAT     = 1;
  localparam int unsigned REG_ACK      = 2;
  localparam int unsigned REG_AUX_MASK = 3;
  localparam int unsigned REG_AUX_STAT = 4;

  // Any enabled pending line raises the level
  function automatic logic any_enabled(input logic [63:0] pend,
                                       input logic [63:0] en);
    return |(pend & en);
  endfunction

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int unsigned W     = 8,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     post,
  input  logic [W-1:0]     clear,
  input  logic             ack_fire,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [W-1:0]     ack_vec,
  output logic [W-1:0]     pend_nxt,
  output logic [W-1:0]     pend_q
);

  localparam logic [W-1:0] ONE = W'(1);

  // Index beyond the line count shifts out to zero
  always_comb begin
    ack_vec = '0;
    if (ack_fire && (32'(ack_idx) < W)) ack_vec = ONE << ack_idx;
  end

  // Removal has priority over setting
  assign pend_nxt = (pend_q | post) & ~(clear | ack_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_nxt;
  end

endmodule

// File: rtl/irq_host_regs.sv
module irq_host_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [W-1:0]      host_wdata,
  input  logic [W-1:0]      pend_q,
  output logic [W-1:0]      host_rdata,
  output logic [W-1:0]      en_nxt,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      aux_q,
  output logic              mask_wr_ev,
  output logic              ack_fire,
  output logic [IDX_W-1:0]  ack_idx
);

  logic sel_en, sel_stat, sel_ack, sel_aux;

  assign sel_en   = (host_addr == ADDR_W'(REG_EN));
  assign sel_stat = (host_addr == ADDR_W'(REG_STAT));
  assign sel_ack  = (host_addr == ADDR_W'(REG_ACK));
  assign sel_aux  = (host_addr == ADDR_W'(REG_AUX_MASK));

  assign mask_wr_ev = host_wr && sel_en;
  assign ack_fire   = host_wr && sel_ack;
  assign ack_idx    = host_wdata[IDX_W-1:0];

  // Enable mask is kept in active-high form
  assign en_nxt = mask_wr_ev ? ~host_wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      aux_q <= '0;
    end else begin
      en_q <= en_nxt;
      if (host_wr && sel_aux) aux_q <= host_wdata;
    end
  end

  always_comb begin
    host_rdata = '0;
    if (sel_en)        host_rdata = ~en_q;
    else if (sel_stat) host_rdata = pend_q;
    else if (sel_aux)  host_rdata = aux_q;
  end

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track
  import irq_agg_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         any_evt,
  input  logic [W-1:0] pend_nxt,
  input  logic [W-1:0] en_nxt,
  output logic         irq_q
);

  logic lvl_nxt;

  assign lvl_nxt = any_enabled(64'(pend_nxt), 64'(en_nxt));

  // Re-evaluated only on events; changes only if the condition differs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         irq_q <= 1'b0;
    else if (any_evt && lvl_nxt != irq_q) irq_q <= lvl_nxt;
  end

endmodule

// File: rtl/irq_mask_agg.sv
module irq_mask_agg #(
  parameter int unsigned W      = 8,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [W-1:0]      host_wdata,
  output logic [W-1:0]      host_rdata,
  input  logic [W-1:0]      dev_post,
  input  logic [W-1:0]      dev_clear,
  output logic              irq_out
);

  logic [W-1:0]     pend_q, pend_nxt, en_q, en_nxt, aux_q, ack_vec;
  logic             mask_wr_ev, ack_fire, any_evt;
  logic [IDX_W-1:0] ack_idx;

  irq_host_regs #(.W(W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .pend_q(pend_q), .host_rdata(host_rdata),
    .en_nxt(en_nxt), .en_q(en_q), .aux_q(aux_q), .mask_wr_ev(mask_wr_ev),
    .ack_fire(ack_fire), .ack_idx(ack_idx)
  );

  irq_pend_reg #(.W(W), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .post(dev_post), .clear(dev_clear),
    .ack_fire(ack_fire), .ack_idx(ack_idx), .ack_vec(ack_vec),
    .pend_nxt(pend_nxt), .pend_q(pend_q)
  );

  assign any_evt = mask_wr_ev | ack_fire | (|dev_post) | (|dev_clear);

  irq_level_track #(.W(W)) u_lvl (
    .clk(clk), .rst_n(rst_n), .any_evt(any_evt), .pend_nxt(pend_nxt),
    .en_nxt(en_nxt), .irq_q(irq_out)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         host_wr,
  input logic [2:0]   host_addr,
  input logic [W-1:0] host_wdata,
  input logic [W-1:0] host_rdata,
  input logic [W-1:0] dev_post,
  input logic [W-1:0] dev_clear,
  input logic [W-1:0] pend_q,
  input logic [W-1:0] en_q,
  input logic [W-1:0] ack_vec,
  input logic         mask_wr_ev,
  input logic         any_evt,
  input logic         irq_out
);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (pend_q == '0 && en_q == '0 && !irq_out));

  p_mask_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_ev |=> (en_q == ~$past(host_wdata)));

  p_post_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(dev_post & ~dev_clear & ~ack_vec) & ~pend_q) == '0));

  p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(dev_clear | ack_vec)) == '0));

  p_level_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(pend_q & en_q)));

  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> $stable(irq_out));

  p_aux_stat_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == 3'd4) |-> (host_rdata == '0));

endmodule

bind irq_mask_agg irq_agg_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
  .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_post(dev_post),
  .dev_clear(dev_clear), .pend_q(pend_q), .en_q(en_q), .ack_vec(ack_vec),
  .mask_wr_ev(mask_wr_ev), .any_evt(any_evt), .irq_out(irq_out)
);

// File: tb/sim_irq_mask_agg.sv
module sim_irq_mask_agg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic [7:0] dev_post = 8'h00;
  logic [7:0] dev_clear = 8'h00;
  logic       irq_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  irq_mask_agg u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .dev_post(dev_post),
    .dev_clear(dev_clear), .irq_out(irq_out)
  );

  // {op, a, b, exp_stat, exp_irq}; op 1 = host write (a = addr, b = data),
  // op 0 = device pulses (a = post, b = clear)
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {1'b0, 8'h05, 8'h00, 8'h05, 1'b0},  // R3 post, all masked
    {1'b1, 8'h00, 8'hFE, 8'h05, 1'b1},  // R2 R7 enable bit0
    {1'b0, 8'h00, 8'h01, 8'h04, 1'b0},  // R4 clear bit0
    {1'b1, 8'h00, 8'hFB, 8'h04, 1'b1},  // R7 enable bit2
    {1'b1, 8'h02, 8'h02, 8'h00, 1'b0},  // R5 ack idx 2
    {1'b0, 8'h80, 8'h00, 8'h80, 1'b0},  // R3 post bit7, masked
    {1'b1, 8'h00, 8'h7F, 8'h80, 1'b1},  // R7 enable bit7
    {1'b1, 8'h02, 8'hF7, 8'h00, 1'b0},  // R5 upper nibble ignored
    {1'b0, 8'h81, 8'h00, 8'h81, 1'b1},  // R3 post two bits
    {1'b1, 8'h02, 8'h08, 8'h81, 1'b1},  // R5 index 8 clears nothing
    {1'b0, 8'h03, 8'h01, 8'h82, 1'b1},  // R6 clear beats post
    {1'b1, 8'h03, 8'hFF, 8'h82, 1'b1},  // R9 aux mask no effect
    {1'b1, 8'h00, 8'hFF, 8'h82, 1'b0},  // R7 all masked
    {1'b1, 8'h01, 8'h00, 8'h82, 1'b0},  // R10 status write ignored
    {1'b0, 8'h00, 8'hFF, 8'h00, 1'b0}   // R4 clear all
  };

  task automatic check(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic hwrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p, input logic [7:0] c);
    @(negedge clk);
    dev_post = p; dev_clear = c;
    @(negedge clk);
    dev_post = 8'h00; dev_clear = 8'h00;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rd(3'd0, d); check("R1 en port", d, 8'hFF);
    rd(3'd1, d); check("R1 status", d, 8'h00);
    rd(3'd3, d); check("R1 aux mask", d, 8'h00);
    check("R1 irq", {7'd0, irq_out}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      if (v[25]) hwrite(v[19:17], v[16:9]);
      else       pulse(v[24:17], v[16:9]);
      rd(3'd1, d); check($sformatf("R3/R4/R5/R6 vec %0d status", i), d, v[8:1]);
      check($sformatf("R7 vec %0d irq", i), {7'd0, irq_out}, {7'd0, v[0]});
    end

    rd(3'd0, d); check("R2 en readback", d, 8'hFF);
    hwrite(3'd0, 8'h3C);
    rd(3'd0, d); check("R2 en readback 3C", d, 8'h3C);
    rd(3'd3, d); check("R9 aux readback", d, 8'hFF);
    hwrite(3'd4, 8'hA5);
    rd(3'd4, d); check("R10 aux status", d, 8'h00);
    hwrite(3'd6, 8'h55);
    rd(3'd6, d); check("R10 unmapped read", d, 8'h00);
    rd(3'd0, d); check("R10 unmapped write no effect", d, 8'h3C);

    // R6: acknowledge and post on bit 4 in one cycle
    @(negedge clk);
    host_wr = 1'b1; host_addr = 3'd2; host_wdata = 8'h04; dev_post = 8'h10;
    @(negedge clk);
    host_wr = 1'b0; dev_post = 8'h00;
    rd(3'd1, d); check("R6 ack beats post", d, 8'h00);

    // R8: level holds across idle cycles
    hwrite(3'd0, 8'hFE);
    pulse(8'h01, 8'h00);
    check("R7 raised", {7'd0, irq_out}, 8'h01);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 idle hold", {7'd0, irq_out}, 8'h01);
    end

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(3'd1, d); check("R1 status after reset", d, 8'h00);
    rd(3'd0, d); check("R1 en after reset", d, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    summary();
  end

endmodule